// File: doc/BRIEF.md
# Bidirectional Digital Pin Frame Engine

This block handles one frame of sixteen general-purpose digital channels. Each frame arrives as a 32-bit control word. The low half sets each channel's direction, where a 1 makes the channel an input. The high half holds the level to drive on each output channel. The block spreads these channels over two 32-bit pin banks, A and B, through a fixed and irregular channel-to-bit map. For each bank it produces three words:

- a new output-enable word, built by read-modify-write of that bank's current value;
- a set mask;
- a clear mask.

It presents these words to the bank registers and holds them until they are accepted. It then samples both banks' input pins and returns the control word with the sampled levels of the input channels merged in.

A frame starts on a transfer request from the converter sequencer. The request is acted on only while the digital enable is high and the transfer index is a multiple of four. After each frame the block moves a word pointer through two ping-pong buffers, so the returned word and its address can be written back to frame memory. A block-boundary pulse swaps the buffers.

Top module: `dpin_frame_engine`

## Requirements
- R1: After reset, `bank_wr` and `done` are 0, `buf_sel` is 0 and `frame_addr` is 0x11000.
- R2: A request (`xfer_req`=1 while idle) starts a frame only if `dig_en`=1 and `xfer_idx` mod 4 equals 0. Any other request produces no `bank_wr`, no `done` and no change of `frame_addr`.
- R3: Each new output-enable word equals that bank's current output-enable word (`oe_a_cur`/`oe_b_cur`, taken at the accepting edge) with only the mapped bits replaced. A mapped bit becomes 0 for an output channel (`ctrl_word[ch]`=0) and 1 for an input channel. Unmapped bits pass through unchanged.
- R4: Set and clear masks start from zero every frame. An output channel whose level bit `ctrl_word[ch+16]` is 1 sets its pin bit in the set mask. An output channel whose level bit is 0 sets its pin bit in the clear mask. Input channels touch neither mask. The set and clear masks of a bank never share a bit, and they never mark a pin whose new enable bit is 1.
- R5: Channel map, which is fixed:
  - Channels 0 to 3 go to bank B bits 2, 3, 5, 4.
  - Channels 4 to 10 go to bank A bits 13, 12, 28, 18, 15, 14, 19.
  - Channels 11 to 15 go to bank B bits 1, 22, 24, 23, 25.
- R6: `bank_wr` rises in the cycle after the accepting edge. It stays high, with all six bank words stable, until a clock edge at which `bank_ack`=1.
- R7: The returned word `wb_word` keeps bits [15:0] and the level bits of output channels. For each input channel, bit ch+16 holds that channel's pin level sampled at the accepting `bank_ack` edge.
- R8: `done` is high for exactly one cycle, the cycle after the `bank_ack` edge. In that cycle `wb_word` and `frame_addr` give the word to return and its address.
- R9: `frame_addr` advances by 4 after each frame. After 256 frames it wraps back to the start of the current buffer.
- R10: A `block_end` pulse toggles `buf_sel` and moves `frame_addr` to the start of the other buffer: 0x11000 for buffer 0, 0x11400 for buffer 1. It takes priority over an advance in the same cycle.
- R11: Requests that arrive while a frame is in progress are ignored. They do not alter the current frame's words or start another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dig_en | input | 1 | Global enable for digital channel processing |
| xfer_req | input | 1 | Converter transfer request |
| xfer_idx | input | XIDX_W | Index of the converter transfer |
| ctrl_word | input | 32 | Frame control word: [31:16] levels, [15:0] directions |
| oe_a_cur | input | 32 | Current output-enable word of bank A (1 = input) |
| oe_b_cur | input | 32 | Current output-enable word of bank B (1 = input) |
| pins_a | input | 32 | Pin levels of bank A |
| pins_b | input | 32 | Pin levels of bank B |
| bank_ack | input | 1 | Bank registers accept the presented words |
| block_end | input | 1 | Block boundary: swap buffers |
| bank_wr | output | 1 | Bank words valid, held until accepted |
| oe_a_new | output | 32 | New output-enable word for bank A |
| set_a | output | 32 | Set mask for bank A |
| clr_a | output | 32 | Clear mask for bank A |
| oe_b_new | output | 32 | New output-enable word for bank B |
| set_b | output | 32 | Set mask for bank B |
| clr_b | output | 32 | Clear mask for bank B |
| done | output | 1 | One-cycle strobe: returned word ready |
| wb_word | output | 32 | Returned control word with sampled input levels |
| frame_addr | output | ADDR_W | Byte address of the current frame word |
| buf_sel | output | 1 | Active ping-pong buffer |

## Verification
Five control-word patterns exercise the main function:

- All channels as outputs, with alternating levels. This separates the set mask from the clear mask and confirms each channel's bit position.
- All channels as inputs, with prior enable words of zero. This proves that every mapped enable bit is forced high and that every pin reaches the returned word's level bit through the map.
- A mixed pattern over enable words full of ones and random-looking data. This shows that unmapped enable bits pass through and that output levels survive the return path.
- A pattern with alternate directions and inverted pin data.
- A pattern with interleaved directions and inverted pin data.

The last two patterns confirm that no channel's sample leaks into a neighbour. Separate tests vary the acceptance delay and inject requests during a frame, which show that the presented words are held and that late requests are dropped. Further tests run the pointer through a full 256-frame wrap and through block boundaries, including one that coincides with a frame's end.

// File: rtl/dpin_pkg.sv
`timescale 1ns/1ps
package dpin_pkg;
    localparam int NCH    = 16;
    localparam int BANK_W = 32;
    localparam int POS_W  = $clog2(BANK_W);

    typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

    typedef struct packed {
        bank_e            bank;
        logic [POS_W-1:0] bit_pos;
    } pin_loc_t;

    // level half is the upper half of the word, direction the lower
    typedef struct packed {
        logic [NCH-1:0] level;
        logic [NCH-1:0] dir;
    } ctrl_word_t;

    typedef struct packed {
        logic [BANK_W-1:0] oe;
        logic [BANK_W-1:0] set_m;
        logic [BANK_W-1:0] clr_m;
    } bank_drive_t;

    typedef enum logic [1:0] {ST_IDLE, ST_DRIVE, ST_DONE} fsm_e;

    function automatic pin_loc_t mk_loc(input bank_e b, input int p);
        pin_loc_t l;
        l.bank    = b;
        l.bit_pos = POS_W'(p);
        return l;
    endfunction

    // fixed channel-to-pin scatter map
    function automatic pin_loc_t chan_loc(input int ch);
        case (ch)
            0:  return mk_loc(BANK_B, 2);
            1:  return mk_loc(BANK_B, 3);
            2:  return mk_loc(BANK_B, 5);
            3:  return mk_loc(BANK_B, 4);
            4:  return mk_loc(BANK_A, 13);
            5:  return mk_loc(BANK_A, 12);
            6:  return mk_loc(BANK_A, 28);
            7:  return mk_loc(BANK_A, 18);
            8:  return mk_loc(BANK_A, 15);
            9:  return mk_loc(BANK_A, 14);
            10: return mk_loc(BANK_A, 19);
            11: return mk_loc(BANK_B, 1);
            12: return mk_loc(BANK_B, 22);
            13: return mk_loc(BANK_B, 24);
            14: return mk_loc(BANK_B, 23);
            default: return mk_loc(BANK_B, 25);
        endcase
    endfunction
endpackage

// File: rtl/dpin_scatter.sv
`timescale 1ns/1ps
module dpin_scatter
    import dpin_pkg::*;
#(
    parameter bank_e BANK = BANK_A
) (
    input  ctrl_word_t        ctrl,
    input  logic [BANK_W-1:0] oe_cur,
    output bank_drive_t       drv
);
    always_comb begin
        pin_loc_t loc;
        drv.oe    = oe_cur;
        drv.set_m = '0;
        drv.clr_m = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            loc = chan_loc(ch);
            if (loc.bank == BANK) begin
                if (ctrl.dir[ch]) begin
                    drv.oe[loc.bit_pos] = 1'b1;
                end else begin
                    drv.oe[loc.bit_pos] = 1'b0;
                    if (ctrl.level[ch]) drv.set_m[loc.bit_pos] = 1'b1;
                    else                drv.clr_m[loc.bit_pos] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dpin_gather.sv
`timescale 1ns/1ps
module dpin_gather
    import dpin_pkg::*;
(
    input  ctrl_word_t        ctrl,
    input  logic [BANK_W-1:0] pins_a,
    input  logic [BANK_W-1:0] pins_b,
    output ctrl_word_t        merged
);
    always_comb begin
        pin_loc_t loc;
        merged = ctrl;
        for (int ch = 0; ch < NCH; ch++) begin
            loc = chan_loc(ch);
            if (ctrl.dir[ch]) begin
                merged.level[ch] = (loc.bank == BANK_A) ? pins_a[loc.bit_pos]
                                                        : pins_b[loc.bit_pos];
            end
        end
    end
endmodule

// File: rtl/dpin_frame_ptr.sv
`timescale 1ns/1ps
module dpin_frame_ptr #(
    parameter int ADDR_W  = 20,
    parameter int BASE    = 'h11000,
    parameter int BUF_OFS = 'h400,
    parameter int FRAMES  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              block_end,
    output logic [ADDR_W-1:0] addr,
    output logic              buf_sel
);
    localparam int FIDX_W = $clog2(FRAMES);

    logic [FIDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            buf_sel <= 1'b0;
        end else if (block_end) begin
            idx_q   <= '0;
            buf_sel <= ~buf_sel;
        end else if (advance) begin
            idx_q   <= (idx_q == FIDX_W'(FRAMES - 1)) ? '0 : idx_q + 1'b1;
        end
    end

    assign addr = ADDR_W'(BASE)
                + (buf_sel ? ADDR_W'(BUF_OFS) : '0)
                + ADDR_W'({idx_q, 2'b00});
endmodule

// File: rtl/dpin_frame_engine.sv
`timescale 1ns/1ps
module dpin_frame_engine
    import dpin_pkg::*;
#(
    parameter int XIDX_W  = 8,
    parameter int ADDR_W  = 20,
    parameter int BASE    = 'h11000,
    parameter int BUF_OFS = 'h400,
    parameter int FRAMES  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dig_en,
    input  logic              xfer_req,
    input  logic [XIDX_W-1:0] xfer_idx,
    input  logic [31:0]       ctrl_word,
    input  logic [31:0]       oe_a_cur,
    input  logic [31:0]       oe_b_cur,
    input  logic [31:0]       pins_a,
    input  logic [31:0]       pins_b,
    input  logic              bank_ack,
    input  logic              block_end,
    output logic              bank_wr,
    output logic [31:0]       oe_a_new,
    output logic [31:0]       set_a,
    output logic [31:0]       clr_a,
    output logic [31:0]       oe_b_new,
    output logic [31:0]       set_b,
    output logic [31:0]       clr_b,
    output logic              done,
    output logic [31:0]       wb_word,
    output logic [ADDR_W-1:0] frame_addr,
    output logic              buf_sel
);
    localparam logic [XIDX_W-1:0] PHASE_MASK = XIDX_W'(3);

    fsm_e        state_q;
    ctrl_word_t  ctrl_in, ctrl_q, merged, wb_q;
    bank_drive_t drv_a, drv_b, drv_a_q, drv_b_q;
    logic        accept;

    assign ctrl_in = ctrl_word_t'(ctrl_word);
    assign accept  = (state_q == ST_IDLE) && xfer_req && dig_en
                   && ((xfer_idx & PHASE_MASK) == '0);

    dpin_scatter #(.BANK(BANK_A)) u_scatter_a (.ctrl(ctrl_in), .oe_cur(oe_a_cur), .drv(drv_a));
    dpin_scatter #(.BANK(BANK_B)) u_scatter_b (.ctrl(ctrl_in), .oe_cur(oe_b_cur), .drv(drv_b));

    dpin_gather u_gather (.ctrl(ctrl_q), .pins_a(pins_a), .pins_b(pins_b), .merged(merged));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
            drv_a_q <= '0;
            drv_b_q <= '0;
            wb_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    ctrl_q  <= ctrl_in;
                    drv_a_q <= drv_a;
                    drv_b_q <= drv_b;
                    state_q <= ST_DRIVE;
                end
                ST_DRIVE: if (bank_ack) begin
                    wb_q    <= merged;
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    dpin_frame_ptr #(
        .ADDR_W(ADDR_W), .BASE(BASE), .BUF_OFS(BUF_OFS), .FRAMES(FRAMES)
    ) u_ptr (
        .clk(clk), .rst(rst), .advance(done), .block_end(block_end),
        .addr(frame_addr), .buf_sel(buf_sel)
    );

    assign bank_wr  = (state_q == ST_DRIVE);
    assign done     = (state_q == ST_DONE);
    assign oe_a_new = drv_a_q.oe;
    assign set_a    = drv_a_q.set_m;
    assign clr_a    = drv_a_q.clr_m;
    assign oe_b_new = drv_b_q.oe;
    assign set_b    = drv_b_q.set_m;
    assign clr_b    = drv_b_q.clr_m;
    assign wb_word  = wb_q;
endmodule

// File: rtl/dpin_frame_engine_chk.sv
`timescale 1ns/1ps
module dpin_frame_engine_chk #(
    parameter int ADDR_W  = 20,
    parameter int BASE    = 'h11000,
    parameter int BUF_OFS = 'h400
) (
    input logic              clk,
    input logic              rst,
    input logic              bank_ack,
    input logic              block_end,
    input logic              bank_wr,
    input logic [31:0]       oe_a_new,
    input logic [31:0]       set_a,
    input logic [31:0]       clr_a,
    input logic [31:0]       oe_b_new,
    input logic [31:0]       set_b,
    input logic [31:0]       clr_b,
    input logic              done,
    input logic [ADDR_W-1:0] frame_addr,
    input logic              buf_sel
);
    // R6
    drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_wr && !bank_ack) |=> (bank_wr && $stable(oe_a_new) && $stable(set_a)
            && $stable(clr_a) && $stable(oe_b_new) && $stable(set_b) && $stable(clr_b)));

    // R4
    mask_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        bank_wr |-> (((set_a & clr_a) == 32'h0) && ((set_b & clr_b) == 32'h0)));

    // R4
    mask_output_only_chk: assert property (@(posedge clk) disable iff (rst)
        bank_wr |-> ((((set_a | clr_a) & oe_a_new) == 32'h0)
                  && (((set_b | clr_b) & oe_b_new) == 32'h0)));

    // R8
    done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bank_wr && bank_ack));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_addr >= ADDR_W'(BASE)) && (frame_addr < ADDR_W'(BASE + 2 * BUF_OFS))
        && (frame_addr[1:0] == 2'b00));

    // R10
    buf_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        block_end |=> (buf_sel != $past(buf_sel)));
endmodule

bind dpin_frame_engine dpin_frame_engine_chk #(
    .ADDR_W(ADDR_W), .BASE(BASE), .BUF_OFS(BUF_OFS)
) u_chk (
    .clk(clk), .rst(rst), .bank_ack(bank_ack), .block_end(block_end),
    .bank_wr(bank_wr), .oe_a_new(oe_a_new), .set_a(set_a), .clr_a(clr_a),
    .oe_b_new(oe_b_new), .set_b(set_b), .clr_b(clr_b), .done(done),
    .frame_addr(frame_addr), .buf_sel(buf_sel)
);

// File: tb/dpin_frame_engine_test.sv
`timescale 1ns/1ps
module dpin_frame_engine_test;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dig_en = 1'b0, xfer_req = 1'b0, bank_ack = 1'b0, block_end = 1'b0;
    logic [7:0]    xfer_idx = '0;
    logic [31:0]   ctrl_word = '0, oe_a_cur = '0, oe_b_cur = '0, pins_a = '0, pins_b = '0;
    logic          bank_wr, done, buf_sel;
    logic [31:0]   oe_a_new, set_a, clr_a, oe_b_new, set_b, clr_b, wb_word;
    logic [AW-1:0] frame_addr;

    int checks = 0;
    int failures = 0;
    int exp_idx = 0;
    int exp_buf = 0;
    int frame_no = 1;

    always #2.5 clk = ~clk;

    dpin_frame_engine uut (
        .clk(clk), .rst(rst), .dig_en(dig_en), .xfer_req(xfer_req), .xfer_idx(xfer_idx),
        .ctrl_word(ctrl_word), .oe_a_cur(oe_a_cur), .oe_b_cur(oe_b_cur),
        .pins_a(pins_a), .pins_b(pins_b), .bank_ack(bank_ack), .block_end(block_end),
        .bank_wr(bank_wr), .oe_a_new(oe_a_new), .set_a(set_a), .clr_a(clr_a),
        .oe_b_new(oe_b_new), .set_b(set_b), .clr_b(clr_b), .done(done),
        .wb_word(wb_word), .frame_addr(frame_addr), .buf_sel(buf_sel)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bench copy of the map in R5: returns {bank(1=B), bit[4:0]}
    function automatic logic [5:0] pin_of(input int ch);
        int a_bits[7] = '{13, 12, 28, 18, 15, 14, 19};
        int b_lo[4]   = '{2, 3, 5, 4};
        int b_hi[5]   = '{1, 22, 24, 23, 25};
        if (ch < 4)       return {1'b1, 5'(b_lo[ch])};
        else if (ch < 11) return {1'b0, 5'(a_bits[ch-4])};
        else              return {1'b1, 5'(b_hi[ch-11])};
    endfunction

    // kind: 0 = oe, 1 = set, 2 = clear
    function automatic logic [31:0] ref_bank(input int kind, input bit bank_b,
                                             input logic [31:0] cw, input logic [31:0] oe);
        logic [31:0] r = (kind == 0) ? oe : 32'h0;
        for (int ch = 0; ch < 16; ch++) begin
            logic [5:0] p = pin_of(ch);
            if (p[5] == bank_b) begin
                if (kind == 0) r[p[4:0]] = cw[ch] ? 1'b1 : 1'b0;
                else if (!cw[ch] && kind == 1 && cw[ch+16]) r[p[4:0]] = 1'b1;
                else if (!cw[ch] && kind == 2 && !cw[ch+16]) r[p[4:0]] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_wb(input logic [31:0] cw, input logic [31:0] pa,
                                           input logic [31:0] pb);
        logic [31:0] r = cw;
        for (int ch = 0; ch < 16; ch++) begin
            logic [5:0] p = pin_of(ch);
            if (cw[ch]) r[ch+16] = p[5] ? pb[p[4:0]] : pa[p[4:0]];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_addr();
        return 32'h11000 + 32'(exp_buf) * 32'h400 + 32'(exp_idx) * 4;
    endfunction

    // one complete frame; wait_c cycles of held drive before acceptance; poke injects busy requests
    task automatic run_frame(input logic [31:0] cw, oa, ob, pa, pb, input int wait_c,
                             input bit poke, input bit full);
        logic [31:0] s_oa, s_sa, s_ca, s_ob, s_sb, s_cb;
        @(negedge clk);
        ctrl_word = cw; oe_a_cur = oa; oe_b_cur = ob; pins_a = pa; pins_b = pb;
        xfer_idx = 8'(frame_no * 4); frame_no++;
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        if (full) begin
            chk(bank_wr === 1'b1, "R6 bank_wr after request", 32'(bank_wr), 32'h1);
            chk(oe_a_new === ref_bank(0, 0, cw, oa), "R3 oe bank A", oe_a_new, ref_bank(0, 0, cw, oa));
            chk(oe_b_new === ref_bank(0, 1, cw, ob), "R3 oe bank B", oe_b_new, ref_bank(0, 1, cw, ob));
            chk(set_a === ref_bank(1, 0, cw, oa), "R4 R5 set bank A", set_a, ref_bank(1, 0, cw, oa));
            chk(clr_a === ref_bank(2, 0, cw, oa), "R4 R5 clear bank A", clr_a, ref_bank(2, 0, cw, oa));
            chk(set_b === ref_bank(1, 1, cw, ob), "R4 R5 set bank B", set_b, ref_bank(1, 1, cw, ob));
            chk(clr_b === ref_bank(2, 1, cw, ob), "R4 R5 clear bank B", clr_b, ref_bank(2, 1, cw, ob));
        end
        s_oa = oe_a_new; s_sa = set_a; s_ca = clr_a; s_ob = oe_b_new; s_sb = set_b; s_cb = clr_b;
        for (int i = 0; i < wait_c; i++) begin
            if (poke) begin
                ctrl_word = ~cw; oe_a_cur = ~oa; oe_b_cur = ~ob; xfer_req = 1'b1; xfer_idx = 8'd0;
            end
            @(negedge clk);
            chk(bank_wr === 1'b1 && done === 1'b0, "R6 drive held", 32'(bank_wr), 32'h1);
            chk({oe_a_new, set_a, clr_a} === {s_oa, s_sa, s_ca} &&
                {oe_b_new, set_b, clr_b} === {s_ob, s_sb, s_cb},
                "R6 R11 words stable", set_a ^ s_sa ^ oe_b_new ^ s_ob, 32'h0);
        end
        xfer_req = 1'b0;
        bank_ack = 1'b1;
        @(negedge clk);
        bank_ack = 1'b0;
        chk(done === 1'b1, "R8 done strobe", 32'(done), 32'h1);
        if (full || poke)
            chk(wb_word === ref_wb(cw, pa, pb), "R7 R11 returned word", wb_word, ref_wb(cw, pa, pb));
        chk(32'(frame_addr) === exp_addr(), "R8 R9 frame address", 32'(frame_addr), exp_addr());
        @(negedge clk);
        chk(done === 1'b0 && bank_wr === 1'b0, "R8 R11 single frame", {30'h0, done, bank_wr}, 32'h0);
        exp_idx = (exp_idx + 1) % 256;
    endtask

    task automatic t_reset();
        chk(bank_wr === 1'b0 && done === 1'b0, "R1 reset strobes", {30'h0, bank_wr, done}, 32'h0);
        chk(buf_sel === 1'b0, "R1 reset buffer", 32'(buf_sel), 32'h0);
        chk(32'(frame_addr) === 32'h11000, "R1 reset address", 32'(frame_addr), 32'h11000);
    endtask

    task automatic t_patterns();
        run_frame(32'hA5C3_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 0, 0, 1);
        run_frame(32'h0000_FFFF, 32'h0, 32'h0, 32'h9ABC_DEF0, 32'h0F1E_2D3C, 0, 0, 1);
        run_frame(32'h5A5A_0F0F, 32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 1);
        run_frame(32'h3C69_AAAA, 32'h8765_4321, 32'h0, 32'h5555_5555, 32'hAAAA_AAAA, 0, 0, 1);
        run_frame(32'hFFFF_5555, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'hAAAA_AAAA, 32'h5555_5555, 0, 0, 1);
    endtask

    task automatic t_hold_busy();
        run_frame(32'h1234_8421, 32'h0000_FFFF, 32'hFFFF_0000, 32'h1357_9BDF, 32'h2468_ACE0, 3, 1, 1);
    endtask

    task automatic t_gating();
        logic [31:0] a0 = 32'(frame_addr);
        @(negedge clk);
        dig_en = 1'b0; xfer_idx = 8'd0; ctrl_word = 32'h0000_FFFF; xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        chk(bank_wr === 1'b0, "R2 disabled request ignored", 32'(bank_wr), 32'h0);
        @(negedge clk);
        dig_en = 1'b1; xfer_idx = 8'd6; xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        chk(bank_wr === 1'b0, "R2 off-phase request ignored", 32'(bank_wr), 32'h0);
        @(negedge clk);
        chk(done === 1'b0 && 32'(frame_addr) === a0, "R2 address unchanged", 32'(frame_addr), a0);
    endtask

    task automatic t_wrap();
        logic [31:0] a0 = 32'(frame_addr);
        for (int n = 0; n < 256; n++)
            run_frame(32'(n * 32'h0001_0003), 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 0);
        chk(32'(frame_addr) === a0, "R9 wrap after 256 frames", 32'(frame_addr), a0);
    endtask

    task automatic t_block();
        run_frame(32'h00FF_0000, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 0);
        @(negedge clk);
        block_end = 1'b1;
        @(negedge clk);
        block_end = 1'b0;
        exp_buf = 1; exp_idx = 0;
        chk(buf_sel === 1'b1 && 32'(frame_addr) === 32'h11400, "R10 swap to buffer 1",
            32'(frame_addr), 32'h11400);
        run_frame(32'h0F0F_0000, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 0);
        // boundary coinciding with a frame's end
        @(negedge clk);
        ctrl_word = 32'h0; xfer_idx = 8'd0; xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0; bank_ack = 1'b1;
        @(negedge clk);
        bank_ack = 1'b0; block_end = 1'b1;
        chk(done === 1'b1, "R8 done before boundary", 32'(done), 32'h1);
        @(negedge clk);
        block_end = 1'b0;
        exp_buf = 0; exp_idx = 0;
        chk(buf_sel === 1'b0 && 32'(frame_addr) === 32'h11000, "R10 boundary over advance",
            32'(frame_addr), 32'h11000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        dig_en = 1'b1;
        t_patterns();
        t_hold_busy();
        t_gating();
        t_block();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule